// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

The unit owns a small word-addressed memory and shares it among several requester ports. Each request carries an operation code, a word address and a write value. Five operations are offered: plain load, plain store, swap, test-and-set and fetch-and-increment. Every operation hands the word's previous contents back to the requester. Lock variables therefore need no software retry loop. A test-and-set that returns 0 means the caller now owns the lock. A return value of 1 means another requester holds it.

A round-robin arbiter lets at most one request through per cycle. An atomic operation reads the word in its accept cycle and writes the result in the following cycle. During that second cycle no port is granted, so no other access can fall between the read and the write. The memory is a register file that is cleared by reset.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads 0, no `rsp_valid_o` bit is set, and `req_ready_o` is 0 while no request is valid.
- R2: A load (op code 0) returns the addressed word and leaves the memory unchanged.
- R3: A store (op code 1) writes `req_wdata` to the word and returns the word's previous value.
- R4: A swap (op code 2) returns the previous value and writes `req_wdata`.
- R5: A test-and-set (op code 3) returns the previous value and writes 1, whatever that previous value was. When two requesters race on a free lock word, exactly one receives 0.
- R6: A fetch-and-increment (op code 4) returns the previous value and writes that value plus one, modulo 2^DATA_W, so 2^DATA_W-1 becomes 0.
- R7: In any cycle at most one `req_ready_o` bit is set, and only for a port whose `req_valid_i` is set.
- R8: In the cycle after an atomic request (op codes 2 to 4) is accepted, no port is granted. The next accepted access to that word sees the value the atomic operation wrote.
- R9: Grants rotate. After port k is accepted, the next grant goes to the first pending port found in the order k+1, k+2, and so on, wrapping modulo NUM_PORTS. The search starts at port 0 after reset.
- R10: Op codes 5, 6 and 7 behave exactly as a load.
- R11: Exactly one cycle after a request is accepted, only that port's `rsp_valid_o` bit is high for one cycle, and `rsp_rdata_o` carries the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_PORTS | Per-port request valid |
| req_ready_o | output | NUM_PORTS | Per-port accept; a request is taken when valid and ready are both high |
| req_op_i | input | 3*NUM_PORTS | Per-port op code, 3 bits per port, port 0 in the lowest bits |
| req_addr_i | input | ADDR_W*NUM_PORTS | Per-port word address |
| req_wdata_i | input | DATA_W*NUM_PORTS | Per-port write value for store and swap |
| rsp_valid_o | output | NUM_PORTS | One-cycle response strobe for the accepted port |
| rsp_rdata_o | output | DATA_W | Previous word value, shared by all ports and qualified by rsp_valid_o |

## Verification
The bench uses the defaults: four ports, eight words and eight-bit data. At this size it can sweep every address against all eight op codes and reach the wrap of fetch-and-increment from 255. It also drives all fifteen non-empty masks of simultaneous requesters, starting from known arbiter positions. A reference model in the bench predicts three things for each cycle: the next grant, the stalled cycle after each atomic, and the old value returned. With this, races of test-and-set and increment on a shared word are checked down to the individual cycle.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4
    } rmw_op_e;

    // Operations whose write lands one cycle after their read.
    function automatic logic op_is_atomic(logic [OP_W-1:0] op);
        return (op == OP_SWAP) || (op == OP_TAS) || (op == OP_FINC);
    endfunction

endpackage

// File: rtl/rmw_rr_arbiter.sv
module rmw_rr_arbiter #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] grant_idx_o,
    output logic             grant_any_o
);

    int  slot;
    logic found;

    always_comb begin
        grant_o     = '0;
        grant_idx_o = '0;
        found       = 1'b0;
        slot        = 0;
        for (int i = 0; i < N; i++) begin
            slot = int'(ptr_i) + i;
            if (slot >= N) begin
                slot = slot - N;
            end
            if (!found && req_i[slot]) begin
                found         = 1'b1;
                grant_o[slot] = 1'b1;
                grant_idx_o   = IDX_W'(slot);
            end
        end
        grant_any_o = found;
    end

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] new_o,
    output logic              writes_o
);

    always_comb begin
        new_o    = old_i;
        writes_o = 1'b0;
        unique case (op_i)
            OP_STORE: begin
                new_o    = wdata_i;
                writes_o = 1'b1;
            end
            OP_SWAP: begin
                new_o    = wdata_i;
                writes_o = 1'b1;
            end
            OP_TAS: begin
                new_o    = DATA_W'(1);
                writes_o = 1'b1;
            end
            OP_FINC: begin
                new_o    = old_i + DATA_W'(1);
                writes_o = 1'b1;
            end
            default: begin
                new_o    = old_i;
                writes_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rmw_regfile.sv
module rmw_regfile #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_d[w] = mem_q[w];
        end
        if (wr_en_i) begin
            mem_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= mem_d[w];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import rmw_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_PORTS-1:0]        req_valid_i,
    output logic [NUM_PORTS-1:0]        req_ready_o,
    input  logic [OP_W*NUM_PORTS-1:0]   req_op_i,
    input  logic [ADDR_W*NUM_PORTS-1:0] req_addr_i,
    input  logic [DATA_W*NUM_PORTS-1:0] req_wdata_i,
    output logic [NUM_PORTS-1:0]        rsp_valid_o,
    output logic [DATA_W-1:0]           rsp_rdata_o
);

    typedef struct packed {
        logic                 busy;
        logic [IDX_W-1:0]     ptr;
        logic [ADDR_W-1:0]    hold_addr;
        logic [DATA_W-1:0]    hold_val;
        logic [NUM_PORTS-1:0] rsp_valid;
        logic [DATA_W-1:0]    rsp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_PORTS-1:0] arb_req;
    logic [NUM_PORTS-1:0] grant;
    logic [IDX_W-1:0]     grant_idx;
    logic                 grant_any;

    logic [OP_W-1:0]      sel_op;
    logic [ADDR_W-1:0]    sel_addr;
    logic [DATA_W-1:0]    sel_wdata;
    logic [DATA_W-1:0]    rd_data;
    logic [DATA_W-1:0]    alu_new;
    logic                 alu_writes;

    logic                 mem_we;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [DATA_W-1:0]    mem_wdata;

    // While an atomic write is pending the arbiter sees no requests.
    assign arb_req = ctl_q.busy ? '0 : req_valid_i;

    rmw_rr_arbiter #(
        .N     (NUM_PORTS),
        .IDX_W (IDX_W)
    ) u_arb (
        .req_i       (arb_req),
        .ptr_i       (ctl_q.ptr),
        .grant_o     (grant),
        .grant_idx_o (grant_idx),
        .grant_any_o (grant_any)
    );

    assign sel_op    = req_op_i[int'(grant_idx)*OP_W +: OP_W];
    assign sel_addr  = req_addr_i[int'(grant_idx)*ADDR_W +: ADDR_W];
    assign sel_wdata = req_wdata_i[int'(grant_idx)*DATA_W +: DATA_W];

    rmw_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_addr_i (sel_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (mem_we),
        .wr_addr_i (mem_waddr),
        .wr_data_i (mem_wdata)
    );

    rmw_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_i     (sel_op),
        .old_i    (rd_data),
        .wdata_i  (sel_wdata),
        .new_o    (alu_new),
        .writes_o (alu_writes)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = '0;
        mem_we          = 1'b0;
        mem_waddr       = sel_addr;
        mem_wdata       = alu_new;

        if (ctl_q.busy) begin
            // Second half of an atomic: commit the held result.
            mem_we     = 1'b1;
            mem_waddr  = ctl_q.hold_addr;
            mem_wdata  = ctl_q.hold_val;
            ctl_d.busy = 1'b0;
        end else if (grant_any) begin
            ctl_d.rsp_valid = grant;
            ctl_d.rsp_data  = rd_data;
            ctl_d.ptr       = (grant_idx == IDX_W'(NUM_PORTS - 1))
                            ? '0 : grant_idx + IDX_W'(1);
            if (op_is_atomic(sel_op)) begin
                ctl_d.busy      = 1'b1;
                ctl_d.hold_addr = sel_addr;
                ctl_d.hold_val  = alu_new;
            end else if (alu_writes) begin
                mem_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready_o = grant;
    assign rsp_valid_o = ctl_q.rsp_valid;
    assign rsp_rdata_o = ctl_q.rsp_data;

endmodule

// File: rtl/rmw_checker.sv
module rmw_checker
    import rmw_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [NUM_PORTS-1:0]      req_valid_i,
    input logic [NUM_PORTS-1:0]      req_ready_o,
    input logic [OP_W*NUM_PORTS-1:0] req_op_i,
    input logic [NUM_PORTS-1:0]      rsp_valid_o
);

    logic acc_atomic;

    always_comb begin
        acc_atomic = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_valid_i[p] && req_ready_o[p] &&
                op_is_atomic(req_op_i[p*OP_W +: OP_W])) begin
                acc_atomic = 1'b1;
            end
        end
    end

    assert_single_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(req_ready_o));

    assert_grant_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o & ~req_valid_i) == '0);

    assert_atomic_lockout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_atomic |=> req_ready_o == '0);

    assert_rsp_follows_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> rsp_valid_o == $past(req_valid_i & req_ready_o));

    assert_rsp_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rsp_valid_o));

endmodule

bind atomic_rmw_unit rmw_checker #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_rmw_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_op_i    (req_op_i),
    .rsp_valid_o (rsp_valid_o)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic [NP-1:0]    req_valid_i = '0;
    logic [NP-1:0]    req_ready_o;
    logic [3*NP-1:0]  req_op_i = '0;
    logic [AW*NP-1:0] req_addr_i = '0;
    logic [DW*NP-1:0] req_wdata_i = '0;
    logic [NP-1:0]    rsp_valid_o;
    logic [DW-1:0]    rsp_rdata_o;

    atomic_rmw_unit #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_ready_o (req_ready_o),
        .req_op_i    (req_op_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] mem_m [DEPTH];
    int            ptr_m = 0;
    logic [2:0]    op_b    [NP];
    logic [AW-1:0] addr_b  [NP];
    logic [DW-1:0] wd_b    [NP];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(logic [2:0] op);
        case (op)
            3'd0: return "R2 load";
            3'd1: return "R3 store";
            3'd2: return "R4 swap";
            3'd3: return "R5 test-and-set";
            3'd4: return "R6 fetch-increment";
            default: return "R10 spare code";
        endcase
    endfunction

    // Present requests on the masked ports at once and follow every
    // grant and response against the bench model until all are served.
    task automatic serve(logic [NP-1:0] mask);
        logic [NP-1:0] pend;
        logic [NP-1:0] r, exp_r;
        bit busy, busy_nx, acc;
        int idx, guard;
        logic [DW-1:0] old;
        @(negedge clk_i);
        for (int p = 0; p < NP; p++) begin
            req_op_i[p*3 +: 3]     = op_b[p];
            req_addr_i[p*AW +: AW] = addr_b[p];
            req_wdata_i[p*DW +: DW] = wd_b[p];
        end
        req_valid_i = mask;
        pend  = mask;
        busy  = 1'b0;
        guard = 0;
        while (pend != '0 && guard < 40) begin
            guard++;
            #1;
            r = req_ready_o;
            exp_r = '0;
            idx = 0;
            if (!busy) begin
                for (int i = 0; i < NP; i++) begin
                    int j;
                    j = (ptr_m + i) % NP;
                    if (exp_r == '0 && pend[j]) begin
                        exp_r[j] = 1'b1;
                        idx = j;
                    end
                end
            end
            chk(busy ? "R8 no grant in atomic write cycle" : "R9 round-robin grant",
                32'(r), 32'(exp_r));
            acc = (exp_r != '0);
            busy_nx = 1'b0;
            old = mem_m[addr_b[idx]];
            if (acc) begin
                case (op_b[idx])
                    3'd1, 3'd2: mem_m[addr_b[idx]] = wd_b[idx];
                    3'd3: mem_m[addr_b[idx]] = DW'(1);
                    3'd4: mem_m[addr_b[idx]] = old + DW'(1);
                    default: ;
                endcase
                busy_nx = (op_b[idx] >= 3'd2 && op_b[idx] <= 3'd4);
                ptr_m = (idx + 1) % NP;
            end
            @(negedge clk_i);
            if (acc) begin
                chk("R11 response strobe", 32'(rsp_valid_o), 32'(1 << idx));
                chk(op_tag(op_b[idx]), 32'(rsp_rdata_o), 32'(old));
                req_valid_i[idx] = 1'b0;
                pend[idx] = 1'b0;
            end else begin
                chk("R11 no response without accept", 32'(rsp_valid_o), 32'd0);
            end
            busy = busy_nx;
        end
        chk("R9 all requesters served", 32'(pend), 32'd0);
        req_valid_i = '0;
    endtask

    task automatic one(int p, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] wd);
        op_b[p] = op; addr_b[p] = a; wd_b[p] = wd;
        serve(NP'(1) << p);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < DEPTH; w++) mem_m[w] = '0;
        for (int p = 0; p < NP; p++) begin
            op_b[p] = '0; addr_b[p] = '0; wd_b[p] = '0;
        end
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
        chk("R1 no response after reset", 32'(rsp_valid_o), 32'd0);
        chk("R1 no ready while idle", 32'(req_ready_o), 32'd0);

        // R1: every word reads zero after reset (model starts at zero).
        for (int a = 0; a < DEPTH; a++) one(a % NP, 3'd0, AW'(a), '0);

        // Sweep every address against every op code, then read back.
        for (int a = 0; a < DEPTH; a++) begin
            for (int op = 0; op < 8; op++) begin
                one((a + op) % NP, 3'(op), AW'(a), DW'(a * 37 + op * 11 + 5));
                one((a + op + 1) % NP, 3'd0, AW'(a), '0);
            end
        end

        // R6: increment wraps from all ones to zero.
        one(0, 3'd1, AW'(3), DW'(255));
        one(1, 3'd4, AW'(3), '0);
        one(2, 3'd0, AW'(3), '0);

        // R5: lock acquire on a free word, then a second attempt sees it held.
        one(3, 3'd1, AW'(5), '0);
        one(0, 3'd3, AW'(5), '0);
        one(1, 3'd3, AW'(5), '0);
        one(2, 3'd0, AW'(5), '0);

        // R5/R8: all ports race test-and-set on a freed lock word.
        for (int k = 0; k < NP; k++) begin
            one(k, 3'd1, AW'(6), '0);
            for (int p = 0; p < NP; p++) begin
                op_b[p] = 3'd3; addr_b[p] = AW'(6); wd_b[p] = '0;
            end
            serve('1);
        end

        // R9: mixed operations on one word from every arbiter start point.
        for (int k = 0; k < NP; k++) begin
            for (int p = 0; p < NP; p++) begin
                op_b[p] = 3'((p + k) % 5); addr_b[p] = AW'(2);
                wd_b[p] = DW'(16 * p + k);
            end
            serve('1);
        end

        // R9/R6: every non-empty requester mask incrementing one counter.
        for (int m = 1; m < (1 << NP); m++) begin
            for (int p = 0; p < NP; p++) begin
                op_b[p] = 3'd4; addr_b[p] = AW'(7); wd_b[p] = '0;
            end
            serve(NP'(m));
        end
        one(0, 3'd0, AW'(7), '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule